// File: doc/BRIEF.md
# Receive Queue Event Interrupt Controller

This block gathers four single-cycle event pulses from a receive packet path and turns them into one level-sensitive interrupt for a host processor. The four events are an overflow of the FIFO that moves received frames from the MAC toward external memory, an overflow of the receive queue itself, and the queue fill level passing its high watermark or its low watermark. Each event sets a sticky bit in a status register. The interrupt output stays high while any status bit is set and its enable bit is also set.

The host reaches two byte-wide registers over a simple strobe bus. One register holds the interrupt enables and the other holds the latched status. The high-watermark and low-watermark bits sit in swapped positions in these two registers, so the block pairs each status bit with the correct enable bit. A host read of the status register returns the latched bits and clears them. An event that arrives in the same cycle as that read is kept for the next read.

The block has no state machine. Its whole behaviour is held in two small registers, which are the enable register and the sticky status register, plus a registered read-data path.

Top module: `rxq_irq_ctrl`

## Requirements
- R1: After the active-high synchronous reset, the enable register and the status register are both zero, `irq` is low and `bus_rdata` is zero.
- R2: The enable register is at address 0x15C. Its bit 3 enables the FIFO-overflow interrupt, bit 2 the queue-overflow interrupt, bit 1 the low-watermark interrupt and bit 0 the high-watermark interrupt. A write stores bits 3..0. Bits 7..4 read as zero and writes to them have no effect.
- R3: The status register is at address 0x15D. Bit 3 shows a FIFO overflow, bit 2 a queue overflow, bit 1 a high-watermark crossing and bit 0 a low-watermark crossing. Bits 7..4 read as zero.
- R4: A one-cycle pulse on an event input sets its status bit on the next clock edge. The bit then stays set until the status register is read.
- R5: A read of the status register returns the current latched bits and clears all of them.
- R6: If an event pulse arrives in the same cycle as a status read, that read returns the bit as it was before the event, and the bit is set afterwards.
- R7: `irq` is high exactly when at least one of these pairs is set: status bit 3 with enable bit 3, status bit 2 with enable bit 2, status bit 1 with enable bit 0, or status bit 0 with enable bit 1.
- R8: A write to the enable register changes `irq` only after the clock edge that takes the write. Clearing an enable bit leaves the matching status bit unchanged.
- R9: Writes to the status register have no effect on its contents.
- R10: Read data is registered. It appears on `bus_rdata` after the clock edge that samples `bus_rd`. A read of any address other than the two registers returns zero and has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 12 | Host register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| evt_fifo_ovf | input | 1 | Pulse: the MAC-to-memory FIFO overflowed |
| evt_queue_ovf | input | 1 | Pulse: the receive queue overflowed |
| evt_high_wm | input | 1 | Pulse: the queue level crossed the high watermark |
| evt_low_wm | input | 1 | Pulse: the queue level crossed the low watermark |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters. These are a 12-bit address with the enable register at 0x15C and the status register at 0x15D, 8-bit data and four event sources. With these values the bench can drive every address the requirements name, plus an unmapped address, 0x100. Because there are only four sources, the bench can cover each status bit and each enable pairing one at a time. That includes the crossed watermark pairing and the case where an event coincides with a clearing read.

// File: rtl/rxq_irq_pkg.sv
package rxq_irq_pkg;

    localparam int unsigned NUM_EVT = 4;

    // Status register bit positions; the enable register swaps 0 and 1.
    typedef enum int unsigned {
        EV_LOW_WM   = 0,
        EV_HIGH_WM  = 1,
        EV_QUEUE_OV = 2,
        EV_FIFO_OV  = 3
    } evt_idx_e;

    // Map a status bit position onto the enable bit that gates it.
    function automatic int unsigned enable_pos(input int unsigned sts_pos);
        if (sts_pos == int'(EV_LOW_WM))  return 1;
        if (sts_pos == int'(EV_HIGH_WM)) return 0;
        return sts_pos;
    endfunction

endpackage

// File: rtl/rxq_evt_latch.sv
module rxq_evt_latch #(
    parameter int unsigned N = rxq_irq_pkg::NUM_EVT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic         clr,
    output logic [N-1:0] sts
);

    logic [N-1:0] sts_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                sts_q[i] <= 1'b0;
            end else begin
                // A new event always wins over the clearing read.
                sts_q[i] <= (sts_q[i] & ~clr) | evt[i];
            end
        end

        assert_event_sets_R4: assert property (@(posedge clk) disable iff (rst)
            evt[i] |=> sts_q[i]);

        assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
            (sts_q[i] && !clr) |=> sts_q[i]);

        assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
            (clr && !evt[i]) |=> !sts_q[i]);

        assert_no_spurious_set_R4: assert property (@(posedge clk) disable iff (rst)
            (!sts_q[i] && !evt[i]) |=> !sts_q[i]);
    end

    assign sts = sts_q;

endmodule

// File: rtl/rxq_host_regs.sv
module rxq_host_regs #(
    parameter int unsigned     ADDR_W   = 12,
    parameter int unsigned     DATA_W   = 8,
    parameter int unsigned     N        = rxq_irq_pkg::NUM_EVT,
    parameter logic [ADDR_W-1:0] ENA_ADDR = 12'h15C,
    parameter logic [ADDR_W-1:0] STS_ADDR = 12'h15D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic [N-1:0]      sts,
    output logic [N-1:0]      en,
    output logic              sts_clr,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned PAD_W = DATA_W - N;

    logic              hit_ena;
    logic              hit_sts;
    logic [N-1:0]      en_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_mux;
    logic              unused_wdata_hi;

    assign hit_ena = (addr == ENA_ADDR);
    assign hit_sts = (addr == STS_ADDR);
    assign unused_wdata_hi = ^wdata[DATA_W-1:N];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr && hit_ena) begin
            en_q <= wdata[N-1:0];
        end
    end

    always_comb begin
        rd_mux = '0;
        if (hit_ena) begin
            rd_mux = {{PAD_W{1'b0}}, en_q};
        end else if (hit_sts) begin
            rd_mux = {{PAD_W{1'b0}}, sts};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd) begin
            rdata_q <= rd_mux;
        end
    end

    assign sts_clr = rd && hit_sts;
    assign en      = en_q;
    assign rdata   = rdata_q;

    assert_upper_bits_zero_R2: assert property (@(posedge clk) disable iff (rst)
        rdata_q[DATA_W-1:N] == '0);

    assert_enable_holds_R8: assert property (@(posedge clk) disable iff (rst)
        !(wr && hit_ena) |=> $stable(en_q));

    assert_rdata_holds_R10: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rdata_q));

endmodule

// File: rtl/rxq_irq_combine.sv
module rxq_irq_combine #(
    parameter int unsigned N = rxq_irq_pkg::NUM_EVT
) (
    input  logic [N-1:0] sts,
    input  logic [N-1:0] en,
    output logic         irq
);

    logic [N-1:0] gated;

    for (genvar i = 0; i < N; i++) begin : g_pair
        always_comb begin
            gated[i] = sts[i] & en[rxq_irq_pkg::enable_pos(i)];
        end
    end

    assign irq = |gated;

endmodule

// File: rtl/rxq_irq_ctrl.sv
module rxq_irq_ctrl #(
    parameter int unsigned       ADDR_W   = 12,
    parameter int unsigned       DATA_W   = 8,
    parameter logic [ADDR_W-1:0] ENA_ADDR = 12'h15C,
    parameter logic [ADDR_W-1:0] STS_ADDR = 12'h15D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              evt_fifo_ovf,
    input  logic              evt_queue_ovf,
    input  logic              evt_high_wm,
    input  logic              evt_low_wm,
    output logic              irq
);

    import rxq_irq_pkg::*;

    localparam int unsigned N = NUM_EVT;

    logic [N-1:0] evt_vec;
    logic [N-1:0] sts;
    logic [N-1:0] en;
    logic         sts_clr;

    always_comb begin
        evt_vec              = '0;
        evt_vec[EV_LOW_WM]   = evt_low_wm;
        evt_vec[EV_HIGH_WM]  = evt_high_wm;
        evt_vec[EV_QUEUE_OV] = evt_queue_ovf;
        evt_vec[EV_FIFO_OV]  = evt_fifo_ovf;
    end

    rxq_host_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .N        (N),
        .ENA_ADDR (ENA_ADDR),
        .STS_ADDR (STS_ADDR)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (bus_addr),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .wdata   (bus_wdata),
        .sts     (sts),
        .en      (en),
        .sts_clr (sts_clr),
        .rdata   (bus_rdata)
    );

    rxq_evt_latch #(
        .N (N)
    ) u_latch (
        .clk (clk),
        .rst (rst),
        .evt (evt_vec),
        .clr (sts_clr),
        .sts (sts)
    );

    rxq_irq_combine #(
        .N (N)
    ) u_comb (
        .sts (sts),
        .en  (en),
        .irq (irq)
    );

    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |-> !irq);

    assert_no_status_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (sts == '0) |-> !irq);

    assert_status_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_rd && (bus_addr == STS_ADDR) && (evt_vec == '0)) |=> $stable(sts));

    assert_disable_keeps_status_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_rd && (bus_addr == ENA_ADDR)) |=> (sts == ($past(sts) | $past(evt_vec))));

endmodule

// File: tb/rxq_irq_ctrl_tb.sv
module rxq_irq_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_ENA = 12'h15C;
    localparam logic [11:0] A_STS = 12'h15D;
    localparam logic [11:0] A_NONE = 12'h100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        evt_fifo_ovf = 1'b0;
    logic        evt_queue_ovf = 1'b0;
    logic        evt_high_wm = 1'b0;
    logic        evt_low_wm = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxq_irq_ctrl u_dut (
        .clk           (clk),
        .rst           (rst),
        .bus_addr      (bus_addr),
        .bus_wr        (bus_wr),
        .bus_rd        (bus_rd),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .evt_fifo_ovf  (evt_fifo_ovf),
        .evt_queue_ovf (evt_queue_ovf),
        .evt_high_wm   (evt_high_wm),
        .evt_low_wm    (evt_low_wm),
        .irq           (irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    // mask bit order: 3 fifo, 2 queue, 1 high, 0 low
    task automatic pulse(input logic [3:0] m);
        @(negedge clk);
        {evt_fifo_ovf, evt_queue_ovf, evt_high_wm, evt_low_wm} = m;
        @(negedge clk);
        {evt_fifo_ovf, evt_queue_ovf, evt_high_wm, evt_low_wm} = 4'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 irq after reset", {7'b0, irq}, 8'h00);
        chk("R1 rdata after reset", bus_rdata, 8'h00);
        bus_read(A_ENA, d); chk("R1 enable reset", d, 8'h00);
        bus_read(A_STS, d); chk("R1 status reset", d, 8'h00);
    endtask

    task automatic t_enable_rw();
        logic [7:0] d;
        bus_write(A_ENA, 8'hFF); bus_read(A_ENA, d); chk("R2 enable upper ignored", d, 8'h0F);
        bus_write(A_ENA, 8'hA5); bus_read(A_ENA, d); chk("R2 enable readback", d, 8'h05);
        bus_write(A_ENA, 8'h00);
    endtask

    task automatic t_layout();
        logic [7:0] d;
        pulse(4'b1000); bus_read(A_STS, d); chk("R3 fifo ovf bit3", d, 8'h08);
        pulse(4'b0100); bus_read(A_STS, d); chk("R3 queue ovf bit2", d, 8'h04);
        pulse(4'b0010); bus_read(A_STS, d); chk("R3 high wm bit1", d, 8'h02);
        pulse(4'b0001); bus_read(A_STS, d); chk("R3 low wm bit0", d, 8'h01);
        chk("R7 irq low with all enables off", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_sticky_clear();
        logic [7:0] d;
        pulse(4'b0010);
        repeat (5) @(negedge clk);
        bus_read(A_STS, d); chk("R4 bit stays set", d, 8'h02);
        bus_read(A_STS, d); chk("R5 read cleared status", d, 8'h00);
        pulse(4'b1001); pulse(4'b0100);
        bus_read(A_STS, d); chk("R4 bits accumulate", d, 8'h0D);
        bus_read(A_STS, d); chk("R5 all bits cleared", d, 8'h00);
    endtask

    task automatic t_collision();
        logic [7:0] d;
        @(negedge clk);
        bus_addr = A_STS; bus_rd = 1'b1; evt_low_wm = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; evt_low_wm = 1'b0;
        chk("R6 colliding read sees old value", bus_rdata, 8'h00);
        bus_read(A_STS, d); chk("R6 colliding event kept", d, 8'h01);
        pulse(4'b0100);
        @(negedge clk);
        bus_addr = A_STS; bus_rd = 1'b1; evt_high_wm = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; evt_high_wm = 1'b0;
        chk("R6 read returns pre-event bits", bus_rdata, 8'h04);
        bus_read(A_STS, d); chk("R6 only new event remains", d, 8'h02);
    endtask

    task automatic t_irq_map();
        logic [7:0] d;
        bus_write(A_ENA, 8'h01);
        pulse(4'b0001); chk("R7 low wm not gated by enable bit0", {7'b0, irq}, 8'h00);
        pulse(4'b0010); chk("R7 high wm gated by enable bit0", {7'b0, irq}, 8'h01);
        bus_read(A_STS, d); chk("R7 irq drops after clear", {7'b0, irq}, 8'h00);
        bus_write(A_ENA, 8'h02);
        pulse(4'b0010); chk("R7 high wm not gated by enable bit1", {7'b0, irq}, 8'h00);
        pulse(4'b0001); chk("R7 low wm gated by enable bit1", {7'b0, irq}, 8'h01);
        bus_read(A_STS, d);
        bus_write(A_ENA, 8'h08);
        pulse(4'b0100); chk("R7 queue ovf masked", {7'b0, irq}, 8'h00);
        pulse(4'b1000); chk("R7 fifo ovf enabled", {7'b0, irq}, 8'h01);
        bus_read(A_STS, d);
        bus_write(A_ENA, 8'h04);
        pulse(4'b0100); chk("R7 queue ovf enabled", {7'b0, irq}, 8'h01);
        bus_read(A_STS, d);
        bus_write(A_ENA, 8'h00);
    endtask

    task automatic t_enable_timing();
        logic [7:0] d;
        pulse(4'b0010);
        chk("R8 irq low before enable", {7'b0, irq}, 8'h00);
        @(negedge clk);
        bus_addr = A_ENA; bus_wdata = 8'h01; bus_wr = 1'b1;
        #1;
        chk("R8 irq unchanged before edge", {7'b0, irq}, 8'h00);
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R8 irq after enable edge", {7'b0, irq}, 8'h01);
        bus_write(A_ENA, 8'h00);
        chk("R8 irq off after disable", {7'b0, irq}, 8'h00);
        bus_read(A_STS, d); chk("R8 disable keeps status", d, 8'h02);
    endtask

    task automatic t_status_write();
        logic [7:0] d;
        pulse(4'b0100);
        bus_write(A_STS, 8'h00);
        bus_read(A_STS, d); chk("R9 write cannot clear status", d, 8'h04);
        bus_write(A_STS, 8'hFF);
        bus_read(A_STS, d); chk("R9 write cannot set status", d, 8'h00);
    endtask

    task automatic t_other_addr();
        logic [7:0] d;
        bus_write(A_ENA, 8'h08);
        pulse(4'b1000);
        bus_read(A_NONE, d); chk("R10 unmapped read is zero", d, 8'h00);
        chk("R10 unmapped read keeps irq", {7'b0, irq}, 8'h01);
        @(negedge clk);
        bus_addr = A_STS; bus_rd = 1'b1;
        #1;
        chk("R10 rdata not yet updated", bus_rdata, 8'h00);
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R10 rdata after edge", bus_rdata, 8'h08);
        chk("R10 status read clears irq", {7'b0, irq}, 8'h00);
        bus_write(A_ENA, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_enable_rw();
        t_layout();
        t_sticky_clear();
        t_collision();
        t_irq_map();
        t_enable_timing();
        t_status_write();
        t_other_addr();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule